// File: doc/BRIEF.md
# Checkerboard Mesh Route Computation Unit

This block computes routes for a two-dimensional mesh in which two kinds of router alternate like the squares of a chessboard. A full router can turn a packet from one dimension to the other. A half router can only pass a packet straight through, or inject and eject it. The block is split into two independent paths. The injection path looks at a packet's source and destination when the packet enters the network. It classifies the pair, then produces a registered header one cycle later. The header holds an error flag, a phase bit, a route mode and a target node. The per-hop path is purely combinational. It is used at every router along the way. From the current coordinates and the header fields it gives the output port, the virtual channel and the updated phase bit.

Most pairs travel X-then-Y. Two kinds of pair travel Y-then-X instead, so that their single turn lands on a full router:
- a full-router source sending to a half router an odd number of columns away in another row;
- a half-router source sending to a full router an even, non-zero number of columns away in another row.

A half-router source sending to a half router an even, non-zero number of columns away in another row takes two legs. The first leg runs Y-then-X to an intermediate full router. The second leg runs X-then-Y from there to the destination. The intermediate node is picked pseudo-randomly from the rectangle spanned by source and destination. A full-router to full-router pair an odd number of columns apart cannot be routed, so the injection path flags it as an error.

Top module: `cbr_route_unit`

## Requirements
- R1: After reset `hdr_valid` is 0. It is 1 in exactly the cycle after a cycle in which `inj_valid` was sampled high, and 0 otherwise.
- R2: Node (x,y) is a full router when x+y is even and a half router otherwise. A full-to-full pair whose column distance is odd gives `hdr_err`=1, `hdr_yx`=0 and `hdr_mode`=0.
- R3: Every routable pair not covered by R4, R5 or R6 gives `hdr_mode`=0 (X-then-Y), `hdr_yx`=0 and a target (`hdr_mid_x`,`hdr_mid_y`) equal to the destination.
- R4: A full source with a half destination an odd number of columns away in a different row gives `hdr_mode`=1, `hdr_yx`=1 and target equal to the destination.
- R5: A half source with a full destination an even, non-zero number of columns away in a different row gives `hdr_mode`=1, `hdr_yx`=1 and target equal to the destination.
- R6: A half source with a half destination an even, non-zero number of columns away in a different row gives `hdr_mode`=2 and `hdr_yx`=1. Its target is a full router that meets all of these: it lies inside the source/destination rectangle, it is an even number of columns from the source, and it is not in the source row.
- R7: The R6 target comes from a free-running pseudo-random sequence, so repeated injections of the same pair at different times yield more than one target.
- R8: Per hop, with `hop_yx_in`=1 and the current node not the target, the packet moves in Y toward the target row first, then in X. In this case `hop_vc`=1 and `hop_yx_out`=1. Port codes: 0 local, 1 east (x+1), 2 west (x-1), 3 north (y+1), 4 south (y-1).
- R9: Per hop, with `hop_yx_in`=1 at the target node, `hop_yx_out` and `hop_vc` are 0 and the port follows X-then-Y toward the destination.
- R10: Per hop, with `hop_yx_in`=0, the packet moves in X first, then in Y, on `hop_vc`=0. The port is local (0) at the destination.
- R11: For every routable pair, following the hop outputs from the header reaches the destination in exactly |dx|+|dy| hops, and the packet changes dimension only at full routers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| inj_valid | input | 1 | Injection request this cycle |
| inj_src_x | input | 3 | Source column |
| inj_src_y | input | 3 | Source row |
| inj_dst_x | input | 3 | Destination column |
| inj_dst_y | input | 3 | Destination row |
| hdr_valid | output | 1 | Header fields valid (one cycle after request) |
| hdr_err | output | 1 | Pair cannot be routed |
| hdr_yx | output | 1 | Phase bit: Y-then-X toward target |
| hdr_mode | output | 2 | 0 X-then-Y, 1 Y-then-X, 2 two-leg |
| hdr_mid_x | output | 3 | Target column (intermediate or destination) |
| hdr_mid_y | output | 3 | Target row |
| hop_cur_x | input | 3 | Current router column |
| hop_cur_y | input | 3 | Current router row |
| hop_dst_x | input | 3 | Header destination column |
| hop_dst_y | input | 3 | Header destination row |
| hop_mid_x | input | 3 | Header target column |
| hop_mid_y | input | 3 | Header target row |
| hop_yx_in | input | 1 | Header phase bit on arrival |
| hop_port | output | 3 | Output port code |
| hop_vc | output | 1 | Virtual channel (1 for Y-then-X leg) |
| hop_yx_out | output | 1 | Phase bit to forward |

## Verification
A wrong classification shows up at the header ports in the cycle after the request. It appears either as a mode or target mismatch, or later as a walked path that turns at a half router or takes extra hops. A fault in the intermediate search gives a target outside the rectangle, on the wrong parity or in the source row. This is visible in the same header cycle. A fault in the pseudo-random source shows up as a frozen target across spaced injections. The per-hop path has no state. Any error there appears on the port and channel outputs as soon as the inputs settle.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    MODE_XY   = 2'd0,
    MODE_YX   = 2'd1,
    MODE_TWO  = 2'd2,
    MODE_NONE = 2'd3
  } mode_e;

  // Full router when the coordinate sum is even.
  function automatic logic full_at(input logic x_lsb, input logic y_lsb);
    return ~(x_lsb ^ y_lsb);
  endfunction
endpackage

// File: rtl/cbr_lfsr.sv
`timescale 1ns/1ps
module cbr_lfsr #(
  parameter int LW = 16,
  parameter logic [LW-1:0] TAPS = 'hB400,
  parameter logic [LW-1:0] SEED = 'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [LW-1:0] state_o
);
  logic [LW-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q[0] ? ((lfsr_q >> 1) ^ TAPS) : (lfsr_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign state_o = lfsr_q;

  // R7: the generator must never lock up in the all-zero state
  p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/cbr_mid_pick.sv
`timescale 1ns/1ps
module cbr_mid_pick #(
  parameter int W  = 6,
  parameter int H  = 6,
  parameter int CW = 3,
  parameter int LW = 16
) (
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [LW-1:0] rnd,
  output logic [CW-1:0] mid_x,
  output logic [CW-1:0] mid_y
);
  localparam int NODES = W * H;

  always_comb begin
    int lo_x, hi_x, lo_y, hi_y, start, pick_hi, pick_any, sel;
    lo_x  = (src_x < dst_x) ? int'(src_x) : int'(dst_x);
    hi_x  = (src_x < dst_x) ? int'(dst_x) : int'(src_x);
    lo_y  = (src_y < dst_y) ? int'(src_y) : int'(dst_y);
    hi_y  = (src_y < dst_y) ? int'(dst_y) : int'(src_y);
    start = int'(rnd) % NODES;
    pick_hi  = -1;
    pick_any = 0;
    // Descending scan: last hit is the lowest legal index (overall and at/after start).
    for (int i = NODES - 1; i >= 0; i--) begin
      int cx, cy;
      cx = i % W;
      cy = i / W;
      if (cx >= lo_x && cx <= hi_x && cy >= lo_y && cy <= hi_y &&
          ((cx + cy) % 2 == 0) && ((cx % 2) == int'(src_x[0])) &&
          cy != int'(src_y)) begin
        pick_any = i;
        if (i >= start) pick_hi = i;
      end
    end
    sel   = (pick_hi >= 0) ? pick_hi : pick_any;
    mid_x = CW'(sel % W);
    mid_y = CW'(sel / W);
  end
endmodule

// File: rtl/cbr_inject.sv
`timescale 1ns/1ps
module cbr_inject
  import cbr_pkg::*;
#(
  parameter int W  = 6,
  parameter int H  = 6,
  parameter int CW = 3,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inj_valid,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [LW-1:0] rnd,
  output logic          hdr_valid_o,
  output logic          hdr_err_o,
  output logic          hdr_yx_o,
  output mode_e         hdr_mode_o,
  output logic [CW-1:0] hdr_mid_x_o,
  output logic [CW-1:0] hdr_mid_y_o
);
  logic          s_full, d_full, col_odd, col_same, row_same;
  logic          err_d, yx_d;
  mode_e         mode_d;
  logic [CW-1:0] pick_x, pick_y, mx_d, my_d;

  logic          valid_q, err_q, yx_q;
  mode_e         mode_q;
  logic [CW-1:0] mx_q, my_q;

  cbr_mid_pick #(.W(W), .H(H), .CW(CW), .LW(LW)) u_pick (
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .rnd(rnd), .mid_x(pick_x), .mid_y(pick_y)
  );

  // Next-state: classify the pair by router parity and distance parity.
  always_comb begin
    s_full   = full_at(src_x[0], src_y[0]);
    d_full   = full_at(dst_x[0], dst_y[0]);
    col_odd  = src_x[0] ^ dst_x[0];
    col_same = (src_x == dst_x);
    row_same = (src_y == dst_y);
    err_d    = 1'b0;
    mode_d   = MODE_XY;
    unique case ({s_full, d_full})
      2'b11: err_d = col_odd;
      2'b10: if (col_odd && !row_same) mode_d = MODE_YX;
      2'b01: if (!col_odd && !col_same && !row_same) mode_d = MODE_YX;
      default: if (!col_odd && !col_same && !row_same) mode_d = MODE_TWO;
    endcase
    yx_d = (mode_d != MODE_XY);
    mx_d = (mode_d == MODE_TWO) ? pick_x : dst_x;
    my_d = (mode_d == MODE_TWO) ? pick_y : dst_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      yx_q    <= 1'b0;
      mode_q  <= MODE_XY;
      mx_q    <= '0;
      my_q    <= '0;
    end else begin
      valid_q <= inj_valid;
      if (inj_valid) begin
        err_q  <= err_d;
        yx_q   <= yx_d;
        mode_q <= mode_d;
        mx_q   <= mx_d;
        my_q   <= my_d;
      end
    end
  end

  assign hdr_valid_o = valid_q;
  assign hdr_err_o   = err_q;
  assign hdr_yx_o    = yx_q;
  assign hdr_mode_o  = mode_q;
  assign hdr_mid_x_o = mx_q;
  assign hdr_mid_y_o = my_q;

  // R1: header appears exactly one cycle after the request
  p_valid_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |=> valid_q);
  p_valid_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(inj_valid));

  // R2: an error only for a full/full pair an odd number of columns apart
  p_err_full_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && err_q) |->
      ($past(src_x[0]) == $past(src_y[0])) && ($past(dst_x[0]) == $past(dst_y[0])) &&
      ($past(src_x[0]) != $past(dst_x[0])));

  // R4: a single-leg Y-then-X header targets the destination
  p_yx_target_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && mode_q == MODE_YX) |-> (mx_q == $past(dst_x) && my_q == $past(dst_y)));

  // R6: the intermediate is a full router
  p_mid_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && mode_q == MODE_TWO) |-> (mx_q[0] == my_q[0]));

  // R6: the intermediate lies within the column span
  p_mid_col_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && mode_q == MODE_TWO) |->
      ((mx_q >= $past(src_x) && mx_q <= $past(dst_x)) ||
       (mx_q <= $past(src_x) && mx_q >= $past(dst_x))));

  // R6: the intermediate lies within the row span
  p_mid_row_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && mode_q == MODE_TWO) |->
      ((my_q >= $past(src_y) && my_q <= $past(dst_y)) ||
       (my_q <= $past(src_y) && my_q >= $past(dst_y))));

  // R6: not in the source row, even column distance from the source
  p_mid_off_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && mode_q == MODE_TWO) |->
      (my_q != $past(src_y) && mx_q[0] == $past(src_x[0])));
endmodule

// File: rtl/cbr_hop.sv
`timescale 1ns/1ps
module cbr_hop
  import cbr_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] mid_x,
  input  logic [CW-1:0] mid_y,
  input  logic          yx_in,
  output port_e         port_o,
  output logic          vc_o,
  output logic          yx_o
);
  logic          at_mid;
  logic [CW-1:0] tx, ty;

  always_comb begin
    at_mid = (cur_x == mid_x) && (cur_y == mid_y);
    yx_o   = yx_in && !at_mid;
    tx     = yx_o ? mid_x : dst_x;
    ty     = yx_o ? mid_y : dst_y;
    port_o = PORT_LOCAL;
    if (yx_o) begin
      if      (cur_y < ty) port_o = PORT_NORTH;
      else if (cur_y > ty) port_o = PORT_SOUTH;
      else if (cur_x < tx) port_o = PORT_EAST;
      else if (cur_x > tx) port_o = PORT_WEST;
    end else begin
      if      (cur_x < tx) port_o = PORT_EAST;
      else if (cur_x > tx) port_o = PORT_WEST;
      else if (cur_y < ty) port_o = PORT_NORTH;
      else if (cur_y > ty) port_o = PORT_SOUTH;
    end
    vc_o = yx_o;
  end
endmodule

// File: rtl/cbr_route_unit.sv
`timescale 1ns/1ps
module cbr_route_unit
  import cbr_pkg::*;
#(
  parameter int MESH_W  = 6,
  parameter int MESH_H  = 6,
  parameter int LFSR_W  = 16,
  parameter int COORD_W = $clog2((MESH_W > MESH_H) ? MESH_W : MESH_H)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inj_valid,
  input  logic [COORD_W-1:0] inj_src_x,
  input  logic [COORD_W-1:0] inj_src_y,
  input  logic [COORD_W-1:0] inj_dst_x,
  input  logic [COORD_W-1:0] inj_dst_y,
  output logic               hdr_valid,
  output logic               hdr_err,
  output logic               hdr_yx,
  output logic [1:0]         hdr_mode,
  output logic [COORD_W-1:0] hdr_mid_x,
  output logic [COORD_W-1:0] hdr_mid_y,
  input  logic [COORD_W-1:0] hop_cur_x,
  input  logic [COORD_W-1:0] hop_cur_y,
  input  logic [COORD_W-1:0] hop_dst_x,
  input  logic [COORD_W-1:0] hop_dst_y,
  input  logic [COORD_W-1:0] hop_mid_x,
  input  logic [COORD_W-1:0] hop_mid_y,
  input  logic               hop_yx_in,
  output logic [2:0]         hop_port,
  output logic               hop_vc,
  output logic               hop_yx_out
);
  logic [LFSR_W-1:0] rnd;
  mode_e             mode_w;
  port_e             port_w;

  cbr_lfsr #(.LW(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state_o(rnd)
  );

  cbr_inject #(.W(MESH_W), .H(MESH_H), .CW(COORD_W), .LW(LFSR_W)) u_inject (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid),
    .src_x(inj_src_x), .src_y(inj_src_y), .dst_x(inj_dst_x), .dst_y(inj_dst_y),
    .rnd(rnd),
    .hdr_valid_o(hdr_valid), .hdr_err_o(hdr_err), .hdr_yx_o(hdr_yx),
    .hdr_mode_o(mode_w), .hdr_mid_x_o(hdr_mid_x), .hdr_mid_y_o(hdr_mid_y)
  );

  cbr_hop #(.CW(COORD_W)) u_hop (
    .cur_x(hop_cur_x), .cur_y(hop_cur_y), .dst_x(hop_dst_x), .dst_y(hop_dst_y),
    .mid_x(hop_mid_x), .mid_y(hop_mid_y), .yx_in(hop_yx_in),
    .port_o(port_w), .vc_o(hop_vc), .yx_o(hop_yx_out)
  );

  assign hdr_mode = mode_w;
  assign hop_port = port_w;
endmodule

// File: tb/sim_cbr_route_unit.sv
`timescale 1ns/1ps
module sim_cbr_route_unit;
  localparam int W = 6;
  localparam int H = 6;

  logic       clk, rst_n, inj_valid;
  logic [2:0] inj_src_x, inj_src_y, inj_dst_x, inj_dst_y;
  logic       hdr_valid, hdr_err, hdr_yx;
  logic [1:0] hdr_mode;
  logic [2:0] hdr_mid_x, hdr_mid_y;
  logic [2:0] hop_cur_x, hop_cur_y, hop_dst_x, hop_dst_y, hop_mid_x, hop_mid_y;
  logic       hop_yx_in;
  logic [2:0] hop_port;
  logic       hop_vc, hop_yx_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cbr_route_unit u0 (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid),
    .inj_src_x(inj_src_x), .inj_src_y(inj_src_y),
    .inj_dst_x(inj_dst_x), .inj_dst_y(inj_dst_y),
    .hdr_valid(hdr_valid), .hdr_err(hdr_err), .hdr_yx(hdr_yx), .hdr_mode(hdr_mode),
    .hdr_mid_x(hdr_mid_x), .hdr_mid_y(hdr_mid_y),
    .hop_cur_x(hop_cur_x), .hop_cur_y(hop_cur_y),
    .hop_dst_x(hop_dst_x), .hop_dst_y(hop_dst_y),
    .hop_mid_x(hop_mid_x), .hop_mid_y(hop_mid_y), .hop_yx_in(hop_yx_in),
    .hop_port(hop_port), .hop_vc(hop_vc), .hop_yx_out(hop_yx_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // 0 X-then-Y, 1 Y-then-X, 2 two-leg, 3 error
  function automatic int exp_mode(input int sx, input int sy, input int dx, input int dy);
    bit sf, df, codd;
    sf   = ((sx + sy) % 2 == 0);
    df   = ((dx + dy) % 2 == 0);
    codd = (iabs(sx - dx) % 2 == 1);
    if (sf && df)  return codd ? 3 : 0;
    if (sf && !df) return (codd && sy != dy) ? 1 : 0;
    if (!sf && df) return (!codd && sx != dx && sy != dy) ? 1 : 0;
    return (!codd && sx != dx && sy != dy) ? 2 : 0;
  endfunction

  task automatic inject(input int sx, input int sy, input int dx, input int dy);
    @(negedge clk);
    inj_valid = 1'b1;
    inj_src_x = 3'(sx); inj_src_y = 3'(sy);
    inj_dst_x = 3'(dx); inj_dst_y = 3'(dy);
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic hop(input int cx, input int cy, input int dx, input int dy,
                     input int mx, input int my, input bit yx);
    hop_cur_x = 3'(cx); hop_cur_y = 3'(cy);
    hop_dst_x = 3'(dx); hop_dst_y = 3'(dy);
    hop_mid_x = 3'(mx); hop_mid_y = 3'(my);
    hop_yx_in = yx;
    #1;
  endtask

  task automatic t_reset;
    check_eq("R1 reset hdr_valid", int'(hdr_valid), 0);
    check_eq("R1 reset hdr_err", int'(hdr_err), 0);
  endtask

  task automatic t_valid_pulse;
    inject(0, 0, 2, 2);
    check_eq("R1 valid after request", int'(hdr_valid), 1);
    check_eq("R3 full-full even mode", int'(hdr_mode), 0);
    check_eq("R3 target x", int'(hdr_mid_x), 2);
    @(negedge clk);
    check_eq("R1 valid drops", int'(hdr_valid), 0);
  endtask

  task automatic t_error;
    inject(0, 0, 1, 1);
    check_eq("R2 err", int'(hdr_err), 1);
    check_eq("R2 yx", int'(hdr_yx), 0);
    check_eq("R2 mode", int'(hdr_mode), 0);
    inject(1, 0, 2, 1);
    check_eq("R3 half-half odd cols err", int'(hdr_err), 0);
    check_eq("R3 half-half odd cols mode", int'(hdr_mode), 0);
    check_eq("R3 half-half odd cols yx", int'(hdr_yx), 0);
  endtask

  task automatic t_yx;
    inject(0, 0, 1, 2);
    check_eq("R4 mode", int'(hdr_mode), 1);
    check_eq("R4 yx", int'(hdr_yx), 1);
    check_eq("R4 target", int'(hdr_mid_x) * 8 + int'(hdr_mid_y), 1 * 8 + 2);
    inject(1, 0, 3, 1);
    check_eq("R5 mode", int'(hdr_mode), 1);
    check_eq("R5 yx", int'(hdr_yx), 1);
    check_eq("R5 target", int'(hdr_mid_x) * 8 + int'(hdr_mid_y), 3 * 8 + 1);
  endtask

  task automatic t_two_leg;
    int mx, my;
    inject(1, 0, 5, 4);
    mx = int'(hdr_mid_x); my = int'(hdr_mid_y);
    check_eq("R6 mode", int'(hdr_mode), 2);
    check_eq("R6 yx", int'(hdr_yx), 1);
    check_eq("R6 target full", (mx + my) % 2, 0);
    check_eq("R6 target in rect", int'(mx >= 1 && mx <= 5 && my >= 0 && my <= 4), 1);
    check_eq("R6 target off source row", int'(my != 0), 1);
    check_eq("R6 target even col distance", (mx - 1) % 2, 0);
  endtask

  task automatic t_random;
    int first, distinct;
    distinct = 0;
    first = -1;
    for (int i = 0; i < 8; i++) begin
      inject(5, 4, 1, 0);
      if (first < 0) first = int'(hdr_mid_x) * 8 + int'(hdr_mid_y);
      else if (first != int'(hdr_mid_x) * 8 + int'(hdr_mid_y)) distinct = 1;
      for (int j = 0; j < i + 1; j++) @(negedge clk);
    end
    check_eq("R7 target varies over time", distinct, 1);
  endtask

  task automatic t_hop_directed;
    hop(0, 0, 3, 2, 3, 2, 1'b0);
    check_eq("R10 x first east", int'(hop_port), 1);
    check_eq("R10 vc", int'(hop_vc), 0);
    hop(3, 0, 3, 2, 3, 2, 1'b0);
    check_eq("R10 then north", int'(hop_port), 3);
    hop(3, 2, 3, 2, 3, 2, 1'b0);
    check_eq("R10 local at dst", int'(hop_port), 0);
    hop(4, 3, 1, 3, 1, 3, 1'b0);
    check_eq("R10 west", int'(hop_port), 2);
    hop(1, 0, 5, 4, 3, 4, 1'b1);
    check_eq("R8 y first north", int'(hop_port), 3);
    check_eq("R8 vc", int'(hop_vc), 1);
    check_eq("R8 yx kept", int'(hop_yx_out), 1);
    hop(1, 4, 5, 4, 3, 4, 1'b1);
    check_eq("R8 then east", int'(hop_port), 1);
    hop(2, 3, 0, 0, 2, 1, 1'b1);
    check_eq("R8 south", int'(hop_port), 4);
    hop(3, 3, 5, 1, 3, 3, 1'b1);
    check_eq("R9 yx cleared", int'(hop_yx_out), 0);
    check_eq("R9 vc", int'(hop_vc), 0);
    check_eq("R9 x first east", int'(hop_port), 1);
  endtask

  task automatic t_walk_all;
    for (int sx = 0; sx < W; sx++)
      for (int sy = 0; sy < H; sy++)
        for (int dx = 0; dx < W; dx++)
          for (int dy = 0; dy < H; dy++) begin
            int em, cx, cy, steps, last, dir, mx, my;
            bit yx, bad_turn, bad_vc;
            string tag;
            inject(sx, sy, dx, dy);
            em = exp_mode(sx, sy, dx, dy);
            tag = (em == 3) ? "R2 class" : (em == 0) ? "R3 class" :
                  (em == 2) ? "R6 class" : (((sx + sy) % 2 == 0) ? "R4 class" : "R5 class");
            check_eq(tag, int'(hdr_err) * 4 + int'(hdr_mode),
                     (em == 3) ? 4 : em);
            if (em != 3) begin
              cx = sx; cy = sy; steps = 0; last = 0;
              yx = hdr_yx; mx = int'(hdr_mid_x); my = int'(hdr_mid_y);
              bad_turn = 0; bad_vc = 0;
              for (int k = 0; k < 4 * (W + H); k++) begin
                hop(cx, cy, dx, dy, mx, my, yx);
                if (hop_port == 3'd0) break;
                if (hop_vc != hop_yx_out) bad_vc = 1;
                dir = (hop_port == 3'd1 || hop_port == 3'd2) ? 1 : 2;
                if (last != 0 && dir != last && ((cx + cy) % 2 != 0)) bad_turn = 1;
                last = dir;
                yx = hop_yx_out;
                case (hop_port)
                  3'd1: cx++;
                  3'd2: cx--;
                  3'd3: cy++;
                  default: cy--;
                endcase
                steps++;
              end
              check_eq("R11 arrival", cx * 8 + cy, dx * 8 + dy);
              check_eq("R11 minimal hops", steps, iabs(sx - dx) + iabs(sy - dy));
              check_eq("R11 turn at full router only", int'(bad_turn), 0);
              check_eq("R8 vc follows phase", int'(bad_vc), 0);
            end
          end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    inj_valid = 1'b0;
    inj_src_x = '0; inj_src_y = '0; inj_dst_x = '0; inj_dst_y = '0;
    hop(0, 0, 0, 0, 0, 0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_valid_pulse();
    t_error();
    t_yx();
    t_two_leg();
    t_random();
    t_hop_directed();
    t_walk_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule